// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block runs complete NAND flash operations over an 8-bit shared command/address/data bus. A host picks an operation code and gives a page (row) number, a column address and a byte count, then pulses `start`. The sequencer drives the latch-enable, chip-enable, write-strobe and read-strobe lines. It puts the command, address and data bytes on the bus in the order the operation needs. It waits on the active-low ready/busy line where the operation requires it and reports one result.

Bytes written to the flash are taken from a valid/ready input stream. Bytes read from the flash go out on a valid/ready output stream. The ready/busy line passes through a synchronizer. Every wait on it is bounded by a cycle limit that the host supplies. After program, program-confirm and erase operations, the sequencer reads the status byte by itself and reports fail when bit 0 of that byte is set.

Each bus byte takes two clock cycles on the write strobe (low, then high). A read byte takes one strobe-low cycle, and the byte is captured at the end of that cycle. Multi-byte addresses go out low byte first. A five-byte address is column[7:0], column[15:8], row[7:0], row[15:8], row[23:16]. A two-byte address is the column only. A three-byte address is the row only.

Top module: `nand_seq`

## Requirements
- R1: `cle` and `ale` are never high together, and `we_n` and `re_n` are never low together. `ce_n` goes low when an operation is accepted and stays low until its `done` pulse. It is high and both strobes are high while idle.
- R2: Page read (op 0) sends command 00h, five address bytes and command 30h. It then waits for `rb_n` high and reads `count` bytes. No read strobe occurs while the device is busy.
- R3: Random data output (op 1) sends 05h, two column bytes and E0h. It reads `count` bytes with no ready wait.
- R4: Cache read continue (op 2, command 31h) and cache read last (op 3, command 3Fh) each send one command, wait for ready and then read `count` bytes.
- R5: Page program (op 4) sends 80h, five address bytes, `count` data bytes in stream order, 10h, a ready wait, then 70h. It reads one status byte and reports fail (1) if status bit 0 is set, otherwise pass (0). Cache program (op 5) is the same but ends the page with 15h.
- R6: Program load (op 6) sends 80h, five address bytes and the data with no confirm. Random data input (op 7) sends 85h, two column bytes and the data. Program confirm (op 8) sends 10h, waits, and checks status as in R5.
- R7: Block erase (op 9) sends 60h, three row bytes, D0h, a ready wait, then the status check of R5.
- R8: Reset (op 10) sends FFh and waits for ready. Read ID (op 11) sends 90h and one 00h address byte, then reads 4 bytes. Read status (op 12) sends 70h and reads 1 byte, and the result is pass.
- R9: If the ready wait does not see `rb_n` high within `tmo_cycles` cycles, the operation ends with result timeout (2). No further bus phase is issued and `ce_n` returns high.
- R10: A read byte on `rd_data` stays valid and stable until `rd_ready`. A write byte is consumed only when `wr_valid` and `wr_ready` are both high. A count of zero skips the data phase.
- R11: `start` is ignored while busy, and op codes 13 to 15 are ignored. In both cases there is no bus activity, no `busy` and no `done`.
- R12: `done` is a single-cycle pulse, and `result` is valid with it: 0 pass, 1 fail, 2 timeout. After reset the block is idle with `done` and `rd_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch the selected operation when idle |
| op | input | 4 | Operation code (0 to 12) |
| page | input | ROW_W | Row (page) address |
| col | input | COL_W | Column address |
| count | input | CNT_W | Data byte count for read and write phases |
| tmo_cycles | input | TMO_W | Ready wait limit in clock cycles |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 pass, 1 fail, 2 timeout |
| wr_data | input | 8 | Byte to program |
| wr_valid | input | 1 | `wr_data` is valid |
| wr_ready | output | 1 | Sequencer takes a write byte |
| rd_data | output | 8 | Byte read from the flash |
| rd_valid | output | 1 | `rd_data` is valid |
| rd_ready | input | 1 | Consumer takes the read byte |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| ce_n | output | 1 | Chip enable, active low |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| dq_out | output | 8 | Bus value driven to the flash |
| dq_oe | output | 1 | Bus output enable |
| dq_in | input | 8 | Bus value from the flash |
| rb_n | input | 1 | Ready/busy, low while busy |

## Verification
A bench-side flash model logs every write-strobe beat with its latch enables. It also answers read strobes from a counting pattern, the status value or the ID bytes. Each operation's logged beat sequence is compared against a list built from R2 to R8, so a wrong command byte, address order or missing confirm shows up directly. Random pages, columns, counts, busy times, status values and stream stalls vary the address bytes and test the handshake under back-pressure. Directed cases cover a stuck busy line, a zero count, a start while busy and illegal op codes, which separate the timeout path and the ignore rules from normal completion.

// File: rtl/nand_seq_pkg.sv
`timescale 1ns/1ps
package nand_seq_pkg;

  localparam logic [3:0] OP_PAGE_RD    = 4'd0;
  localparam logic [3:0] OP_RAND_OUT   = 4'd1;
  localparam logic [3:0] OP_CACHE_NEXT = 4'd2;
  localparam logic [3:0] OP_CACHE_LAST = 4'd3;
  localparam logic [3:0] OP_PROG       = 4'd4;
  localparam logic [3:0] OP_PROG_CACHE = 4'd5;
  localparam logic [3:0] OP_PROG_LOAD  = 4'd6;
  localparam logic [3:0] OP_RAND_IN    = 4'd7;
  localparam logic [3:0] OP_PROG_CONF  = 4'd8;
  localparam logic [3:0] OP_ERASE      = 4'd9;
  localparam logic [3:0] OP_RESET      = 4'd10;
  localparam logic [3:0] OP_READ_ID    = 4'd11;
  localparam logic [3:0] OP_STATUS     = 4'd12;

  // Stage order is the bus order; the sequencer walks it upward.
  typedef enum logic [3:0] {
    ST_IDLE, ST_CMD1, ST_ADDR, ST_DW, ST_CMD2, ST_WAIT, ST_DR, ST_SCMD, ST_SRD, ST_FIN
  } stage_t;

  typedef enum logic [1:0] {RES_PASS = 2'd0, RES_FAIL = 2'd1, RES_TMO = 2'd2} res_t;
  typedef enum logic [1:0] {LEN_HOST, LEN_FOUR, LEN_ONE} len_t;

  typedef struct packed {
    logic       ok;
    logic [7:0] c1;
    logic [2:0] naddr;
    logic       row_only;
    logic       zaddr;
    logic       wr;
    logic       rd;
    len_t       len;
    logic       has_c2;
    logic [7:0] c2;
    logic       wt;
    logic       chk;
  } desc_t;

  function automatic desc_t decode_op(input logic [3:0] op);
    desc_t r;
    r = '0;
    r.ok = 1'b1;
    case (op)
      OP_PAGE_RD:    begin r.c1 = 8'h00; r.naddr = 3'd5; r.rd = 1'b1; r.has_c2 = 1'b1; r.c2 = 8'h30; r.wt = 1'b1; end
      OP_RAND_OUT:   begin r.c1 = 8'h05; r.naddr = 3'd2; r.rd = 1'b1; r.has_c2 = 1'b1; r.c2 = 8'hE0; end
      OP_CACHE_NEXT: begin r.c1 = 8'h31; r.rd = 1'b1; r.wt = 1'b1; end
      OP_CACHE_LAST: begin r.c1 = 8'h3F; r.rd = 1'b1; r.wt = 1'b1; end
      OP_PROG:       begin r.c1 = 8'h80; r.naddr = 3'd5; r.wr = 1'b1; r.has_c2 = 1'b1; r.c2 = 8'h10; r.wt = 1'b1; r.chk = 1'b1; end
      OP_PROG_CACHE: begin r.c1 = 8'h80; r.naddr = 3'd5; r.wr = 1'b1; r.has_c2 = 1'b1; r.c2 = 8'h15; r.wt = 1'b1; r.chk = 1'b1; end
      OP_PROG_LOAD:  begin r.c1 = 8'h80; r.naddr = 3'd5; r.wr = 1'b1; end
      OP_RAND_IN:    begin r.c1 = 8'h85; r.naddr = 3'd2; r.wr = 1'b1; end
      OP_PROG_CONF:  begin r.c1 = 8'h10; r.wt = 1'b1; r.chk = 1'b1; end
      OP_ERASE:      begin r.c1 = 8'h60; r.naddr = 3'd3; r.row_only = 1'b1; r.has_c2 = 1'b1; r.c2 = 8'hD0; r.wt = 1'b1; r.chk = 1'b1; end
      OP_RESET:      begin r.c1 = 8'hFF; r.wt = 1'b1; end
      OP_READ_ID:    begin r.c1 = 8'h90; r.naddr = 3'd1; r.zaddr = 1'b1; r.rd = 1'b1; r.len = LEN_FOUR; end
      OP_STATUS:     begin r.c1 = 8'h70; r.rd = 1'b1; r.len = LEN_ONE; end
      default:       r.ok = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/nand_seq_sync.sv
`timescale 1ns/1ps
module nand_seq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '1;
    else     sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/nand_seq_wait_tmr.sv
`timescale 1ns/1ps
module nand_seq_wait_tmr #(
  parameter int TMO_W = 16,
  parameter int GUARD = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [TMO_W-1:0] limit,
  output logic             guard_ok,
  output logic             expired
);
  logic [TMO_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)   cnt <= '0;
    else if (!expired) cnt <= cnt + 1'b1;
  end

  assign guard_ok = cnt >= TMO_W'(GUARD);
  assign expired  = cnt >= limit;

  AST_TMR_FRESH: assert property (@(posedge clk) disable iff (rst) $rose(run) |-> cnt == '0); // R9
  AST_TMR_FREEZE: assert property (@(posedge clk) disable iff (rst) (run && expired) |=> (!run || $stable(cnt))); // R9
endmodule

// File: rtl/nand_seq.sv
`timescale 1ns/1ps
module nand_seq
  import nand_seq_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int TMO_W  = 16,
  parameter int COL_W  = 16,
  parameter int ROW_W  = 24,
  parameter int GUARD  = 3,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [3:0]       op,
  input  logic [ROW_W-1:0] page,
  input  logic [COL_W-1:0] col,
  input  logic [CNT_W-1:0] count,
  input  logic [TMO_W-1:0] tmo_cycles,
  output logic             busy,
  output logic             done,
  output logic [1:0]       result,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic             cle,
  output logic             ale,
  output logic             ce_n,
  output logic             we_n,
  output logic             re_n,
  output logic [7:0]       dq_out,
  output logic             dq_oe,
  input  logic [7:0]       dq_in,
  input  logic             rb_n
);
  localparam int ADDR_W = ROW_W + COL_W;
  localparam int COL_B  = COL_W / 8;

  stage_t           st;
  logic [1:0]       ph;
  desc_t            d, dcd;
  logic [ROW_W-1:0] row_r;
  logic [COL_W-1:0] col_r;
  logic [CNT_W-1:0] n_r, k;
  logic             stat_fail;
  logic             rb_s, guard_ok, expired;
  logic [ADDR_W-1:0] addr_all;
  int               addr_idx;
  logic [7:0]       beat;
  logic             last_beat, is_cmd, is_wbeat;
  stage_t           nxt;

  function automatic logic present(stage_t s, desc_t dd, logic [CNT_W-1:0] n);
    case (s)
      ST_CMD1, ST_FIN: return 1'b1;
      ST_ADDR:         return dd.naddr != 3'd0;
      ST_DW:           return dd.wr && (n != '0);
      ST_CMD2:         return dd.has_c2;
      ST_WAIT:         return dd.wt;
      ST_DR:           return dd.rd && (n != '0);
      ST_SCMD, ST_SRD: return dd.chk;
      default:         return 1'b0;
    endcase
  endfunction

  function automatic stage_t next_stage(stage_t cur, desc_t dd, logic [CNT_W-1:0] n);
    stage_t r;
    r = ST_FIN;
    for (int i = 9; i >= 1; i--) begin
      if (4'(i) > cur && present(stage_t'(4'(i)), dd, n)) r = stage_t'(4'(i));
    end
    return r;
  endfunction

  nand_seq_sync #(.STAGES(SYNC_N)) u_rb_sync (
    .clk(clk), .rst(rst), .d(rb_n), .q(rb_s)
  );

  nand_seq_wait_tmr #(.TMO_W(TMO_W), .GUARD(GUARD)) u_wait_tmr (
    .clk(clk), .rst(rst), .run(st == ST_WAIT), .limit(tmo_cycles),
    .guard_ok(guard_ok), .expired(expired)
  );

  assign dcd      = decode_op(op);
  assign addr_all = {row_r, col_r};
  assign wr_ready = (st == ST_DW) && (ph == 2'd0);
  assign is_cmd   = (st == ST_CMD1) || (st == ST_CMD2) || (st == ST_SCMD);
  assign is_wbeat = is_cmd || (st == ST_ADDR) || (st == ST_DW);
  assign nxt      = next_stage(st, d, n_r);

  always_comb begin
    addr_idx = d.row_only ? int'(k) + COL_B : int'(k);
    case (st)
      ST_CMD1: beat = d.c1;
      ST_CMD2: beat = d.c2;
      ST_SCMD: beat = 8'h70;
      ST_ADDR: beat = d.zaddr ? 8'h00 : addr_all[addr_idx*8 +: 8];
      ST_DW:   beat = wr_data;
      default: beat = 8'h00;
    endcase
    case (st)
      ST_ADDR:      last_beat = (k + 1'b1) == CNT_W'(d.naddr);
      ST_DW, ST_DR: last_beat = (k + 1'b1) == n_r;
      default:      last_beat = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; ph <= 2'd0; d <= '0; row_r <= '0; col_r <= '0;
      n_r <= '0; k <= '0; stat_fail <= 1'b0;
      busy <= 1'b0; done <= 1'b0; result <= RES_PASS;
      rd_data <= 8'h00; rd_valid <= 1'b0;
      cle <= 1'b0; ale <= 1'b0; ce_n <= 1'b1; we_n <= 1'b1; re_n <= 1'b1;
      dq_out <= 8'h00; dq_oe <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st == ST_IDLE) begin
        if (start && dcd.ok) begin
          d <= dcd; row_r <= page; col_r <= col; k <= '0; ph <= 2'd0;
          case (dcd.len)
            LEN_FOUR: n_r <= CNT_W'(4);
            LEN_ONE:  n_r <= CNT_W'(1);
            default:  n_r <= count;
          endcase
          busy <= 1'b1; ce_n <= 1'b0; stat_fail <= 1'b0; st <= ST_CMD1;
        end
      end else if (is_wbeat) begin
        if (ph == 2'd0) begin
          if (st != ST_DW || wr_valid) begin
            we_n <= 1'b0; dq_oe <= 1'b1; dq_out <= beat;
            cle <= is_cmd; ale <= (st == ST_ADDR); ph <= 2'd1;
          end
        end else begin
          we_n <= 1'b1; cle <= 1'b0; ale <= 1'b0; ph <= 2'd0;
          if (last_beat) begin st <= nxt; k <= '0; end
          else k <= k + 1'b1;
        end
      end else if (st == ST_WAIT) begin
        dq_oe <= 1'b0;
        if (guard_ok && rb_s) st <= nxt;
        else if (expired) begin
          result <= RES_TMO; done <= 1'b1; busy <= 1'b0; ce_n <= 1'b1; st <= ST_IDLE;
        end
      end else if (st == ST_DR || st == ST_SRD) begin
        case (ph)
          2'd0: begin re_n <= 1'b0; dq_oe <= 1'b0; ph <= 2'd1; end
          2'd1: begin
            re_n <= 1'b1;
            if (st == ST_SRD) begin stat_fail <= dq_in[0]; ph <= 2'd0; st <= nxt; end
            else begin rd_data <= dq_in; rd_valid <= 1'b1; ph <= 2'd2; end
          end
          default: if (rd_ready) begin
            rd_valid <= 1'b0; ph <= 2'd0;
            if (last_beat) begin st <= nxt; k <= '0; end
            else k <= k + 1'b1;
          end
        endcase
      end else begin
        result <= (d.chk && stat_fail) ? RES_FAIL : RES_PASS;
        done <= 1'b1; busy <= 1'b0; ce_n <= 1'b1; dq_oe <= 1'b0; st <= ST_IDLE;
      end
    end
  end

  AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (rst) !(cle && ale)); // R1
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst) !(!we_n && !re_n)); // R1
  AST_CE_HELD: assert property (@(posedge clk) disable iff (rst) busy |-> !ce_n); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !busy |-> (we_n && re_n && ce_n)); // R1
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst) (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data))); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R12
  AST_RESULT_CODE: assert property (@(posedge clk) disable iff (rst) done |-> result != 2'd3); // R12
endmodule

// File: tb/nand_seq_tb_top.sv
`timescale 1ns/1ps
module nand_seq_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        start = 1'b0;
  logic [3:0]  op = 4'd0;
  logic [23:0] page = '0;
  logic [15:0] col = '0;
  logic [11:0] count = '0;
  logic [15:0] tmo_cycles = 16'd200;
  logic        busy, done, wr_ready, rd_valid, cle, ale, ce_n, we_n, re_n, dq_oe;
  logic [1:0]  result;
  logic [7:0]  wr_data = 8'h00;
  logic        wr_valid = 1'b0;
  logic        rd_ready = 1'b0;
  logic [7:0]  rd_data, dq_out, dq_in;
  logic        rb_n;

  // flash model state
  logic [7:0]  last_cmd = 8'hFF;
  logic [7:0]  stat_val = 8'h00;
  logic [7:0]  pat_base = 8'h00;
  int          rd_idx = 0, busy_cnt = 0, busy_len = 6, early_rd = 0;
  bit          stuck = 1'b0, prev_re = 1'b1;
  logic [9:0]  log_b[0:63];
  int          log_n = 0;
  // streams
  logic [7:0]  rd_q[0:63];
  int          rd_n = 0, widx = 0;
  logic [7:0]  wbase = 8'h00;
  // expectations
  logic [9:0]  exp_b[0:63];
  int          exp_n = 0;
  int          checks = 0, errors = 0;

  assign rb_n  = !(stuck || busy_cnt > 0);
  assign dq_in = (last_cmd == 8'h70) ? stat_val :
                 (last_cmd == 8'h90) ? 8'(8'hA0 + rd_idx) : 8'(pat_base + rd_idx);

  nand_seq dut_i (
    .clk(clk), .rst(rst), .start(start), .op(op), .page(page), .col(col), .count(count),
    .tmo_cycles(tmo_cycles), .busy(busy), .done(done), .result(result),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .cle(cle), .ale(ale), .ce_n(ce_n), .we_n(we_n), .re_n(re_n),
    .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in), .rb_n(rb_n)
  );

  // flash model: logs write beats, answers reads, drives busy
  initial forever begin
    @(negedge clk);
    if (!we_n) begin
      if (log_n < 64) log_b[log_n] = {cle, ale, dq_out};
      log_n++;
      if (cle) begin
        last_cmd = dq_out; rd_idx = 0;
        if (dq_out inside {8'h30, 8'h31, 8'h3F, 8'h10, 8'h15, 8'hD0, 8'hFF}) busy_cnt = busy_len;
      end
    end else if (busy_cnt > 0) busy_cnt--;
    if (!re_n && !rb_n) early_rd++;
    if (re_n && !prev_re) rd_idx++;
    prev_re = re_n;
  end

  // stream drivers with random stalls
  initial forever begin
    @(negedge clk);
    wr_valid = ($urandom % 4) != 0;
    wr_data  = 8'(wbase + widx);
    if (wr_valid && wr_ready) widx++;
    rd_ready = ($urandom % 3) != 0;
    if (rd_valid && rd_ready) begin
      if (rd_n < 64) rd_q[rd_n] = rd_data;
      rd_n++;
    end
  end

  task automatic chk(bit ok, string rq, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, expv);
    end
  endtask

  task automatic push(bit c, bit a, logic [7:0] b);
    exp_b[exp_n] = {c, a, b};
    exp_n++;
  endtask

  function automatic string req_of(int o);
    case (o)
      0: return "R2";
      1: return "R3";
      2, 3: return "R4";
      4, 5: return "R5";
      6, 7, 8: return "R6";
      9: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic build(int o, logic [23:0] pg, logic [15:0] cl, int n, logic [7:0] wb);
    exp_n = 0;
    case (o)
      0: begin push(1,0,8'h00); push(0,1,cl[7:0]); push(0,1,cl[15:8]);
               push(0,1,pg[7:0]); push(0,1,pg[15:8]); push(0,1,pg[23:16]); push(1,0,8'h30); end
      1: begin push(1,0,8'h05); push(0,1,cl[7:0]); push(0,1,cl[15:8]); push(1,0,8'hE0); end
      2: push(1,0,8'h31);
      3: push(1,0,8'h3F);
      4, 5, 6: begin
        push(1,0,8'h80); push(0,1,cl[7:0]); push(0,1,cl[15:8]);
        push(0,1,pg[7:0]); push(0,1,pg[15:8]); push(0,1,pg[23:16]);
        for (int i = 0; i < n; i++) push(0,0,8'(wb + i));
        if (o == 4) begin push(1,0,8'h10); push(1,0,8'h70); end
        if (o == 5) begin push(1,0,8'h15); push(1,0,8'h70); end
      end
      7: begin push(1,0,8'h85); push(0,1,cl[7:0]); push(0,1,cl[15:8]);
               for (int i = 0; i < n; i++) push(0,0,8'(wb + i)); end
      8: begin push(1,0,8'h10); push(1,0,8'h70); end
      9: begin push(1,0,8'h60); push(0,1,pg[7:0]); push(0,1,pg[15:8]); push(0,1,pg[23:16]);
               push(1,0,8'hD0); push(1,0,8'h70); end
      10: push(1,0,8'hFF);
      11: begin push(1,0,8'h90); push(0,1,8'h00); end
      default: push(1,0,8'h70);
    endcase
  endtask

  task automatic run_op(int o, logic [23:0] pg, logic [15:0] cl, int n, logic [7:0] wb,
                        logic [7:0] stv, int blen, bit stk);
    string rq;
    int t, exp_rd, exp_res, mism;
    rq = req_of(o);
    @(negedge clk);
    log_n = 0; rd_n = 0; widx = 0; wbase = wb; stat_val = stv; busy_len = blen;
    stuck = stk; pat_base = 8'($urandom);
    build(o, pg, cl, n, wb);
    exp_rd  = (o <= 3) ? n : (o == 11) ? 4 : (o == 12) ? 1 : 0;
    exp_res = (o == 4 || o == 5 || o == 8 || o == 9) ? int'(stv[0]) : 0;
    if (stk) begin exp_rd = 0; exp_res = 2; rq = "R9"; end
    op = 4'(o); page = pg; col = cl; count = 12'(n); start = 1'b1;
    @(negedge clk); start = 1'b0;
    t = 0;
    while (!done && t < 5000) begin @(negedge clk); t++; end
    chk(done == 1'b1, rq, "done seen", int'(done), 1);
    chk(result == 2'(exp_res), rq, "result", int'(result), exp_res);
    chk(log_n == exp_n, rq, "beat count", log_n, exp_n);
    mism = -1;
    for (int i = 0; i < exp_n && i < log_n; i++) if (mism < 0 && log_b[i] !== exp_b[i]) mism = i;
    chk(mism < 0, rq, "beat content", (mism < 0) ? 0 : int'(log_b[mism]), (mism < 0) ? 0 : int'(exp_b[mism]));
    chk(rd_n == exp_rd, "R10", "read count", rd_n, exp_rd);
    mism = -1;
    for (int i = 0; i < exp_rd && i < rd_n; i++) begin
      logic [7:0] e;
      e = (o == 11) ? 8'(8'hA0 + i) : (o == 12) ? stv : 8'(pat_base + i);
      if (mism < 0 && rd_q[i] !== e) mism = i;
    end
    chk(mism < 0, "R10", "read data", mism, -1);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R12", "done single pulse", int'(done), 0);
    chk(ce_n == 1'b1, "R1", "ce_n released", int'(ce_n), 1);
    stuck = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int pool[7];
    pool = '{0, 1, 4, 9, 11, 12, 5};
    void'($urandom(32'd2718));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state
    chk(busy == 0 && done == 0 && rd_valid == 0, "R12", "reset idle", {busy, done, rd_valid}, 0);
    chk(ce_n && we_n && re_n && !cle && !ale, "R1", "reset bus", {ce_n, we_n, re_n, cle, ale}, 5'b11100);

    // directed operations
    run_op(0, 24'h123456, 16'h0840, 5, 8'h00, 8'h00, 8, 0);
    run_op(1, 24'h123456, 16'h07FF, 4, 8'h00, 8'h00, 8, 0);
    run_op(2, 24'h0, 16'h0, 3, 8'h00, 8'h00, 10, 0);
    run_op(3, 24'h0, 16'h0, 3, 8'h00, 8'h00, 7, 0);
    run_op(4, 24'hABCDEF, 16'h0010, 6, 8'h40, 8'hC0, 9, 0);
    run_op(4, 24'h000001, 16'h0000, 2, 8'hF0, 8'hC1, 9, 0);
    run_op(5, 24'h00FF00, 16'h0100, 3, 8'h11, 8'h80, 6, 0);
    run_op(6, 24'h345678, 16'h0000, 4, 8'h20, 8'h00, 6, 0);
    run_op(7, 24'h345678, 16'h0833, 3, 8'h90, 8'h00, 6, 0);
    run_op(8, 24'h0, 16'h0, 0, 8'h00, 8'h01, 12, 0);
    run_op(9, 24'h01C0DE, 16'hFFFF, 0, 8'h00, 8'h00, 15, 0);
    run_op(9, 24'h02BEEF, 16'h0000, 0, 8'h00, 8'h01, 15, 0);
    run_op(10, 24'h0, 16'h0, 0, 8'h00, 8'h00, 20, 0);
    run_op(11, 24'h0, 16'h0, 0, 8'h00, 8'h00, 6, 0);
    run_op(12, 24'h0, 16'h0, 0, 8'h00, 8'hE1, 6, 0);
    // zero count skips data phase (R10)
    run_op(0, 24'h000777, 16'h0004, 0, 8'h00, 8'h00, 6, 0);
    // stuck busy line times out (R9)
    tmo_cycles = 16'd40;
    run_op(0, 24'h00AA55, 16'h0002, 4, 8'h00, 8'h00, 6, 1);
    tmo_cycles = 16'd200;

    // illegal op code ignored (R11)
    @(negedge clk);
    log_n = 0; op = 4'd14; start = 1'b1;
    @(negedge clk); start = 1'b0;
    begin
      bit seen;
      seen = 1'b0;
      repeat (30) begin @(negedge clk); if (busy || done) seen = 1'b1; end
      chk(!seen && log_n == 0, "R11", "illegal op ignored", log_n, 0);
    end

    // start while busy ignored (R11)
    log_n = 0; stat_val = 8'h5A; op = 4'd12; start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk); op = 4'd9; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (40) @(negedge clk);
    chk(log_n == 1 && log_b[0] == {2'b10, 8'h70} && !busy, "R11", "start while busy", log_n, 1);

    // random mix
    for (int it = 0; it < 30; it++) begin
      int o;
      o = pool[$urandom % 7];
      run_op(o, 24'($urandom), 16'($urandom % 16'h0840), int'($urandom % 9), 8'($urandom),
             8'($urandom % 4), 5 + int'($urandom % 16), 0);
    end

    chk(early_rd == 0, "R2", "no read while busy", early_rd, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule